// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one programmable logic element for a tiled array of such cells. It holds a 16-bit truth-table configuration that is split into two 8-entry halves. Both halves are addressed by the same three data inputs. A static mode bit picks how the two half-table results are used.

In **function mode** the fourth data input selects between the two halves. The cell then computes any 4-input Boolean function. In **adder mode** the two half-table results become the operands of a one-bit full adder with a carry input, and the cell also drives a carry output.

The combinational result feeds a flip-flop with a clock enable. A second static bit chooses whether the main output shows the registered value or the combinational value. The reset is asynchronous and active low. The cell releases it internally in step with the clock.

Top module: `lcell_core`

## Requirements
- R1: In function mode (`cfg_mode`=0), `comb_out` equals `cfg_table[din]`, where `din[0]`..`din[3]` are the address bits from least to most significant.
- R2: In adder mode (`cfg_mode`=1), `comb_out` equals `cfg_table[din[2:0]] ^ cfg_table[8+din[2:0]] ^ carry_in`.
- R3: In adder mode, `carry_out` is the majority of `cfg_table[din[2:0]]`, `cfg_table[8+din[2:0]]` and `carry_in`.
- R4: In function mode, `carry_out` is 0 for every input.
- R5: In function mode, `carry_in` has no effect on `comb_out`.
- R6: With `ce`=1, `reg_out` takes the value `comb_out` had before each rising clock edge.
- R7: With `ce`=0, `reg_out` keeps its value across clock edges whatever the data inputs do.
- R8: Driving `rst_n` low clears `reg_out` to 0 at once, without waiting for a clock edge. After `rst_n` rises, the register stays cleared for `SYNC_STAGES` (default 2) further rising edges.
- R9: `cell_out` equals `reg_out` when `cfg_use_reg`=1 and `comb_out` when `cfg_use_reg`=0.
- R10: In adder mode, `din[3]` has no effect on `comb_out` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_table | input | 16 | Truth-table configuration; low half is bits 7..0, high half is bits 15..8 |
| cfg_mode | input | 1 | 0 = function mode, 1 = adder mode |
| cfg_use_reg | input | 1 | 1 = `cell_out` shows the register, 0 = the combinational result |
| ce | input | 1 | Clock enable for the register |
| din | input | 4 | Data inputs; bits 2..0 address both halves, bit 3 selects the half in function mode |
| carry_in | input | 1 | Carry into the adder |
| comb_out | output | 1 | Combinational cell result |
| reg_out | output | 1 | Registered cell result |
| cell_out | output | 1 | Selected cell output |
| carry_out | output | 1 | Adder carry; 0 in function mode |

## Verification
The bench sweeps all 16 data patterns against both carry values in both modes, with truth tables that are all-zero, all-one, parity and asymmetric. An asymmetric table exposes swapped halves or reversed address bits, which would show up as a wrong function value. Sweeping the carry in function mode catches a carry that leaks into the function result or a nonzero `carry_out`. Toggling `din[3]` in adder mode catches a design that still lets the half-select act there.

Holding `ce` low while the inputs change catches a register that loads anyway. Pulling `rst_n` low between clock edges catches a reset that waits for a clock. Counting edges after release catches a register that leaves reset too early.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic {
    MODE_FUNC  = 1'b0,
    MODE_ADDER = 1'b1
  } lcell_mode_e;

  typedef struct packed {
    logic res;
    logic cout;
  } lcell_dp_t;

endpackage

// File: rtl/lcell_rst_sync.sv
module lcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int K = 3,
  localparam int ENTRIES = 2 ** K
) (
  input  logic [ENTRIES-1:0] tbl,
  input  logic [K-1:0]       addr,
  output logic               y
);

  always_comb begin
    y = tbl[addr];
  end

endmodule

// File: rtl/lcell_datapath.sv
module lcell_datapath
  import lcell_pkg::*;
(
  input  lcell_mode_e mode,
  input  logic        lo,
  input  logic        hi,
  input  logic        half_sel,
  input  logic        cin,
  output lcell_dp_t   dp
);

  always_comb begin
    dp = '0;
    case (mode)
      MODE_ADDER: begin
        dp.res  = lo ^ hi ^ cin;
        dp.cout = (lo & hi) | (lo & cin) | (hi & cin);
      end
      default: begin
        dp.res  = half_sel ? hi : lo;
        dp.cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
  input  logic clk,
  input  logic srst_n,
  input  logic ce,
  input  logic d,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (ce) q_nxt = d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) q <= 1'b0;
    else         q <= q_nxt;
  end

  a_r6_load: assert property (@(posedge clk) disable iff (!srst_n)
    ce |=> (q == $past(d)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !ce |=> $stable(q));

  a_r8_cleared_at_release: assert property (@(posedge clk)
    $rose(srst_n) |-> (q == 1'b0));

endmodule

// File: rtl/lcell_core.sv
module lcell_core
  import lcell_pkg::*;
#(
  parameter int K           = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NIN   = K + 1,
  localparam int HALF  = 2 ** K,
  localparam int CFG_W = 2 * HALF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_table,
  input  logic             cfg_mode,
  input  logic             cfg_use_reg,
  input  logic             ce,
  input  logic [NIN-1:0]   din,
  input  logic             carry_in,
  output logic             comb_out,
  output logic             reg_out,
  output logic             cell_out,
  output logic             carry_out
);

  logic        srst_n;
  logic [1:0]  half_y;
  lcell_mode_e mode;
  lcell_dp_t   dp;

  assign mode = lcell_mode_e'(cfg_mode);

  lcell_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    lcell_lut #(.K(K)) u_lut (
      .tbl  (cfg_table[h*HALF +: HALF]),
      .addr (din[K-1:0]),
      .y    (half_y[h])
    );
  end

  lcell_datapath u_dp (
    .mode     (mode),
    .lo       (half_y[0]),
    .hi       (half_y[1]),
    .half_sel (din[K]),
    .cin      (carry_in),
    .dp       (dp)
  );

  lcell_reg u_reg (
    .clk    (clk),
    .srst_n (srst_n),
    .ce     (ce),
    .d      (dp.res),
    .q      (reg_out)
  );

  always_comb begin
    comb_out  = dp.res;
    carry_out = dp.cout;
    cell_out  = cfg_use_reg ? reg_out : dp.res;
  end

  a_r1_function: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_FUNC) |-> (comb_out == cfg_table[din]));

  a_r2_sum: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_ADDER) |-> (comb_out == (half_y[0] ^ half_y[1] ^ carry_in)));

  a_r3_carry: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_ADDER) |->
      (carry_out == ($countones({half_y[0], half_y[1], carry_in}) >= 2)));

  a_r4_carry_idle: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_FUNC) |-> (carry_out == 1'b0));

  a_r9_outsel: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_use_reg |-> (cell_out == reg_out));

endmodule

// File: tb/lcell_core_bench.sv
module lcell_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk;
  logic        rst_n;
  logic [15:0] cfg_table;
  logic        cfg_mode;
  logic        cfg_use_reg;
  logic        ce;
  logic [3:0]  din;
  logic        carry_in;
  logic        comb_out;
  logic        reg_out;
  logic        cell_out;
  logic        carry_out;

  int checks;
  int failures;
  logic mreg;

  lcell_core #(.K(3), .SYNC_STAGES(SYNC)) u_lcell_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_table   (cfg_table),
    .cfg_mode    (cfg_mode),
    .cfg_use_reg (cfg_use_reg),
    .ce          (ce),
    .din         (din),
    .carry_in    (carry_in),
    .comb_out    (comb_out),
    .reg_out     (reg_out),
    .cell_out    (cell_out),
    .carry_out   (carry_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b (table=%h mode=%b din=%h cin=%b)",
               tag, act, exp, cfg_table, cfg_mode, din, carry_in);
    end
  endtask

  function automatic logic ref_res(input logic [15:0] t, input logic m,
                                   input logic [3:0] d, input logic ci);
    logic lo, hi;
    lo = t[{1'b0, d[2:0]}];
    hi = t[{1'b1, d[2:0]}];
    if (m) return lo ^ hi ^ ci;
    return t[d];
  endfunction

  function automatic logic ref_cout(input logic [15:0] t, input logic m,
                                    input logic [3:0] d, input logic ci);
    logic lo, hi;
    lo = t[{1'b0, d[2:0]}];
    hi = t[{1'b1, d[2:0]}];
    if (!m) return 1'b0;
    return (lo & hi) | (lo & ci) | (hi & ci);
  endfunction

  // One cycle: apply inputs at the falling edge, check the combinational
  // outputs, then check the register just after the rising edge.
  task automatic step(input logic [3:0] d, input logic ci);
    logic exp;
    string rtag;
    @(negedge clk);
    din = d;
    carry_in = ci;
    #1;
    exp = ref_res(cfg_table, cfg_mode, d, ci);
    if (cfg_mode) rtag = d[3] ? "R10" : "R2";
    else          rtag = ci ? "R5" : "R1";
    chk(rtag, comb_out, exp);
    if (cfg_mode) chk(d[3] ? "R10" : "R3", carry_out, ref_cout(cfg_table, cfg_mode, d, ci));
    else          chk("R4", carry_out, 1'b0);
    if (!cfg_use_reg) chk("R9", cell_out, exp);
    @(posedge clk);
    #1;
    if (ce) mreg = exp;
    chk(ce ? "R6" : "R7", reg_out, mreg);
    if (cfg_use_reg) chk("R9", cell_out, mreg);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    ce = 1'b1;
    cfg_table = 16'hFFFF;
    cfg_mode = 1'b0;
    cfg_use_reg = 1'b1;
    din = 4'h0;
    carry_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", reg_out, 1'b0);
    chk("R9", cell_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // Still cleared while the release travels through the synchronizer.
    for (int i = 0; i < SYNC; i++) begin
      @(posedge clk);
      #1;
      chk("R8", reg_out, 1'b0);
    end
    mreg = 1'b0;
  endtask

  task automatic t_sweep(input logic [15:0] t);
    cfg_table = t;
    ce = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 2; u++) begin
        cfg_mode = m[0];
        cfg_use_reg = u[0];
        for (int v = 0; v < 32; v++) step(v[3:0], v[4]);
      end
    end
  endtask

  task automatic t_ce_hold;
    cfg_table = 16'h5A3C;
    cfg_mode = 1'b0;
    cfg_use_reg = 1'b1;
    ce = 1'b1;
    step(4'h2, 1'b0);
    ce = 1'b0;
    for (int v = 0; v < 16; v++) step(v[3:0], v[0]);
    ce = 1'b1;
    step(4'h3, 1'b0);
    ce = 1'b0;
    for (int v = 15; v >= 0; v--) step(v[3:0], 1'b1);
    ce = 1'b1;
  endtask

  task automatic t_async_reset;
    cfg_table = 16'hFFFF;
    cfg_mode = 1'b0;
    cfg_use_reg = 1'b1;
    ce = 1'b1;
    step(4'h7, 1'b0);
    chk("R6", reg_out, 1'b1);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R8", reg_out, 1'b0);
    chk("R9", cell_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(posedge clk);
      #1;
      chk("R8", reg_out, 1'b0);
    end
    mreg = 1'b0;
    step(4'h9, 1'b0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    mreg = 1'b0;
    t_reset_state();
    t_sweep(16'hA5C3);
    t_sweep(16'h0000);
    t_sweep(16'hFFFF);
    t_sweep(16'h6996);
    t_sweep(16'h8E17);
    t_ce_hold();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule